// File: doc/BRIEF.md
# Bus Bridge Error Capture Unit

This block collects error events inside a bridge between a processor-side local bus slave and a PCI-side master/target. Seven error sources are watched. Each one, when detected, sets a sticky bit in a status vector. Software reads the vector and clears bits by writing ones to them. Every source has a detection mask bit: a masked source is neither detected nor latched. Three further enables gate only the outward signalling: system error, parity error and local bus error. Detection and signalling are therefore independent, and a status bit can be set while its error output stays low.

The unit also decodes incoming local bus requests against the addressed PCI space and flags the transfer kinds the bridge cannot carry. It times the device-select response after each PCI master address phase and declares a master abort when no target claims the cycle in time. A read that ends in master abort still completes on the local bus: every beat returns all-ones data and carries the bus error flag. A posted write that ends in master abort produces a single local bus error pulse instead of stalling the bus.

Top module: `bridge_err_capture`

## Requirements
- R1: Each source sets its own status bit in the clock edge after its event: bit 0 unsupported transfer, bit 1 master abort, bit 2 target abort received as master, bit 3 data parity error as target, bit 4 data parity error as master, bit 5 address parity error as target, bit 6 local bus error.
- R2: While `det_mask[i]` is 1, source i is not detected: its status bit is not set, and a masked master abort neither forces read data nor raises `lb_err_o`.
- R3: `serr_o` is `rpt_serr_en` AND (status bit 2 OR bit 5). `perr_o` is `rpt_perr_en` AND (bit 3 OR bit 4). `lb_err_o` is only raised when both `rpt_lb_en` and `ma_rpt_en` are 1. None of these enables affects status latching.
- R4: A local bus request of kind line-4 (`lb_xfer_kind`=1) or line-8 (=2) with `lb_mem_space`=0 is unsupported.
- R5: A request of kind line-16 (`lb_xfer_kind`=3) is unsupported whatever the space.
- R6: A request with `lb_burst`=1 and `lb_mem_space`=0 is unsupported. A burst to memory space, or a single transfer (kind 0, no burst), is supported.
- R7: After a cycle with `pci_addr_phase`=1, master abort is detected in the TIMEOUT-th following cycle if `pci_devsel` has not been 1 in any of cycles 1 to TIMEOUT. Devsel seen in cycle TIMEOUT still avoids the abort.
- R8: After a master abort on a read, every `rd_beat_vld` beat up to and including the one with `rd_last`=1 shows all-ones on `rd_data_out` with `lb_err_o`=1. Later beats pass `rd_data_in` through.
- R9: A master abort on a write raises `lb_err_o` for exactly one cycle: the cycle in which the abort is detected.
- R10: A write with `csr_wr_en`=1 clears each status bit whose `csr_wdata` bit is 1 and leaves the others unchanged. An event arriving in the same cycle keeps its bit set.
- R11: During reset, the status vector and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_mask | input | 7 | Per-source detection mask, 1 disables |
| rpt_serr_en | input | 1 | Enable for the system error output |
| rpt_perr_en | input | 1 | Enable for the parity error output |
| rpt_lb_en | input | 1 | Enable for the local bus error output |
| ma_rpt_en | input | 1 | Master-abort error enable for local bus signalling |
| lb_req_vld | input | 1 | Local bus request present |
| lb_xfer_kind | input | 2 | 0 single, 1 line-4, 2 line-8, 3 line-16 |
| lb_burst | input | 1 | Request is a burst |
| lb_mem_space | input | 1 | Target is PCI memory space |
| lb_bus_err_in | input | 1 | Local bus error event |
| pci_addr_phase | input | 1 | PCI master address phase |
| pci_is_read | input | 1 | Current master cycle is a read (sampled at address phase) |
| pci_devsel | input | 1 | A target claimed the cycle |
| pci_tgt_abort | input | 1 | Target abort received as master |
| pci_tgt_dperr | input | 1 | Data parity error as target |
| pci_mst_dperr | input | 1 | Data parity error as master |
| pci_tgt_aperr | input | 1 | Address parity error as target |
| rd_beat_vld | input | 1 | Read data beat toward the local bus |
| rd_last | input | 1 | Last beat of the read |
| rd_data_in | input | DW | Read data from the PCI side |
| rd_data_out | output | DW | Read data to the local bus |
| csr_wr_en | input | 1 | Status write strobe |
| csr_wdata | input | 7 | Write-one-to-clear mask |
| status_o | output | 7 | Sticky error status |
| serr_o | output | 1 | System error report |
| perr_o | output | 1 | Parity error report |
| lb_err_o | output | 1 | Local bus error flag |

## Verification
A wrong status bit becomes visible on `status_o` one edge after the event that should or should not have set it. Through the gating, it also appears on `serr_o` or `perr_o` in that same cycle. A timer that is off by one cycle shows as a master abort bit appearing one cycle early or late, or as an abort that fires even though devsel arrived in the last cycle of the window. A stale aborted-read flag shows as forced ones, or as a missing forcing, on the very next read beat. The bench's reference model is compared with every output on every clock, so each such fault is reported in the cycle where it first appears.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int NSRC = 7;

  localparam int ERR_UNSUP   = 0;
  localparam int ERR_MABORT  = 1;
  localparam int ERR_TABORT  = 2;
  localparam int ERR_TDPERR  = 3;
  localparam int ERR_MDPERR  = 4;
  localparam int ERR_TAPERR  = 5;
  localparam int ERR_LBERR   = 6;

  typedef enum logic [1:0] {
    XF_SINGLE = 2'd0,
    XF_LINE4  = 2'd1,
    XF_LINE8  = 2'd2,
    XF_LINE16 = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/bec_xfer_decode.sv
module bec_xfer_decode
  import bec_pkg::*;
(
  input  logic       req_vld,
  input  logic [1:0] kind,
  input  logic       burst,
  input  logic       mem_space,
  output logic       unsup
);
  logic kind_bad;

  always_comb begin
    kind_bad = 1'b0;
    case (kind)
      XF_LINE4, XF_LINE8: kind_bad = !mem_space;  // R4
      XF_LINE16:          kind_bad = 1'b1;        // R5
      default:            kind_bad = 1'b0;
    endcase
    // R6: bursts only toward memory space
    unsup = req_vld && (kind_bad || (burst && !mem_space));
  end
endmodule

// File: rtl/bec_devsel_timer.sv
module bec_devsel_timer #(
  parameter int TIMEOUT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_phase,
  input  logic is_read,
  input  logic devsel,
  output logic abort_evt,
  output logic abort_rd
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;

  always_comb begin
    active_d  = active_q;
    cnt_d     = cnt_q;
    rd_d      = rd_q;
    abort_evt = active_q && !devsel && (cnt_q == LAST);
    if (addr_phase) begin
      active_d = 1'b1;
      cnt_d    = '0;
      rd_d     = is_read;
    end else if (active_q) begin
      if (devsel || cnt_q == LAST) active_d = 1'b0;
      else                         cnt_d    = cnt_q + 1'b1;
    end
  end

  assign abort_rd = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      rd_q     <= rd_d;
    end
  end

  // R7: one abort per address phase, never two cycles in a row
  abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);
endmodule

// File: rtl/bec_status_reg.sv
module bec_status_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_en,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status
);
  logic [N-1:0] stat_q, stat_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      stat_d[i] = stat_q[i];
      if (clr_en && clr_vec[i]) stat_d[i] = 1'b0;
      if (set_vec[i])           stat_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;

  // R10: an event in the clear cycle still leaves its bit set
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R1: a bit only rises after its own event
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/bridge_err_capture.sv
module bridge_err_capture
  import bec_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TIMEOUT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      det_mask,
  input  logic            rpt_serr_en,
  input  logic            rpt_perr_en,
  input  logic            rpt_lb_en,
  input  logic            ma_rpt_en,
  input  logic            lb_req_vld,
  input  logic [1:0]      lb_xfer_kind,
  input  logic            lb_burst,
  input  logic            lb_mem_space,
  input  logic            lb_bus_err_in,
  input  logic            pci_addr_phase,
  input  logic            pci_is_read,
  input  logic            pci_devsel,
  input  logic            pci_tgt_abort,
  input  logic            pci_tgt_dperr,
  input  logic            pci_mst_dperr,
  input  logic            pci_tgt_aperr,
  input  logic            rd_beat_vld,
  input  logic            rd_last,
  input  logic [DW-1:0]   rd_data_in,
  output logic [DW-1:0]   rd_data_out,
  input  logic            csr_wr_en,
  input  logic [6:0]      csr_wdata,
  output logic [6:0]      status_o,
  output logic            serr_o,
  output logic            perr_o,
  output logic            lb_err_o
);
  logic            unsup_raw;
  logic            mabort_raw;
  logic            mabort_is_rd;
  logic [NSRC-1:0] raw_evt;
  logic [NSRC-1:0] det_evt;
  logic            mabort_det;
  logic            rd_abort_q, rd_abort_d;
  logic            lb_sig_en;

  bec_xfer_decode u_dec (
    .req_vld   (lb_req_vld),
    .kind      (lb_xfer_kind),
    .burst     (lb_burst),
    .mem_space (lb_mem_space),
    .unsup     (unsup_raw)
  );

  bec_devsel_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (pci_addr_phase),
    .is_read    (pci_is_read),
    .devsel     (pci_devsel),
    .abort_evt  (mabort_raw),
    .abort_rd   (mabort_is_rd)
  );

  always_comb begin
    raw_evt             = '0;
    raw_evt[ERR_UNSUP]  = unsup_raw;
    raw_evt[ERR_MABORT] = mabort_raw;
    raw_evt[ERR_TABORT] = pci_tgt_abort;
    raw_evt[ERR_TDPERR] = pci_tgt_dperr;
    raw_evt[ERR_MDPERR] = pci_mst_dperr;
    raw_evt[ERR_TAPERR] = pci_tgt_aperr;
    raw_evt[ERR_LBERR]  = lb_bus_err_in;
    det_evt             = raw_evt & ~det_mask;   // R2
  end

  assign mabort_det = det_evt[ERR_MABORT];

  bec_status_reg #(.N(NSRC)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (det_evt),
    .clr_en  (csr_wr_en),
    .clr_vec (csr_wdata),
    .status  (status_o)
  );

  // R8: aborted-read window, closed by the last beat
  always_comb begin
    rd_abort_d = rd_abort_q;
    if (rd_abort_q && rd_beat_vld && rd_last) rd_abort_d = 1'b0;
    if (mabort_det && mabort_is_rd)           rd_abort_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_abort_q <= 1'b0;
    else        rd_abort_q <= rd_abort_d;
  end

  assign lb_sig_en   = rpt_lb_en && ma_rpt_en;
  assign rd_data_out = rd_abort_q ? {DW{1'b1}} : rd_data_in;
  assign lb_err_o    = lb_sig_en &&
                       ((mabort_det && !mabort_is_rd) || (rd_abort_q && rd_beat_vld));
  assign serr_o      = rpt_serr_en && (status_o[ERR_TABORT] || status_o[ERR_TAPERR]);
  assign perr_o      = rpt_perr_en && (status_o[ERR_TDPERR] || status_o[ERR_MDPERR]);

  // R2: the unsupported bit rises only after an unmasked request
  unsup_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[ERR_UNSUP]) |-> $past(lb_req_vld && !det_mask[ERR_UNSUP]));

  // R3: local bus error signalling needs both enables
  lb_err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_err_o |-> (rpt_lb_en && ma_rpt_en));
endmodule

// File: tb/bridge_err_capture_tb.sv
module bridge_err_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int TO = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [6:0]    det_mask;
  logic          rpt_serr_en, rpt_perr_en, rpt_lb_en, ma_rpt_en;
  logic          lb_req_vld;
  logic [1:0]    lb_xfer_kind;
  logic          lb_burst, lb_mem_space, lb_bus_err_in;
  logic          pci_addr_phase, pci_is_read, pci_devsel;
  logic          pci_tgt_abort, pci_tgt_dperr, pci_mst_dperr, pci_tgt_aperr;
  logic          rd_beat_vld, rd_last;
  logic [DW-1:0] rd_data_in, rd_data_out;
  logic          csr_wr_en;
  logic [6:0]    csr_wdata, status_o;
  logic          serr_o, perr_o, lb_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_err_capture #(.DW(DW), .TIMEOUT(TO)) dut_i (.*);

  // reference model state
  int      m_stat;
  bit      m_pend;
  int      m_age;
  bit      m_rd;
  bit      m_abrd;

  function automatic bit m_unsup();
    if (!lb_req_vld) return 0;
    if (lb_xfer_kind == 2'd3) return 1;
    if (!lb_mem_space && (lb_burst || lb_xfer_kind != 2'd0)) return 1;
    return 0;
  endfunction

  function automatic bit m_abort_now();
    return m_pend && !pci_devsel && m_age == TO && !det_mask[1];
  endfunction

  function automatic int m_sets();
    int s = 0;
    if (m_unsup())     s |= 1;
    if (m_abort_now()) s |= 2;
    if (pci_tgt_abort) s |= 4;
    if (pci_tgt_dperr) s |= 8;
    if (pci_mst_dperr) s |= 16;
    if (pci_tgt_aperr) s |= 32;
    if (lb_bus_err_in) s |= 64;
    return s & ~int'(det_mask);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_pend = 0; m_age = 0; m_rd = 0; m_abrd = 0;
    end else begin
      int sets;
      bit ab;
      sets = m_sets();
      ab   = m_abort_now();
      if (csr_wr_en) m_stat = m_stat & ~int'(csr_wdata);
      m_stat = m_stat | sets;
      if (m_abrd && rd_beat_vld && rd_last) m_abrd = 0;
      if (ab && m_rd) m_abrd = 1;
      if (pci_addr_phase) begin
        m_pend = 1; m_age = 1; m_rd = pci_is_read;
      end else if (m_pend) begin
        if (pci_devsel || m_age == TO) m_pend = 0;
        else m_age++;
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_lb;
      e_lb = rpt_lb_en && ma_rpt_en &&
             ((m_abort_now() && !m_rd) || (m_abrd && rd_beat_vld));
      check("R1/R10 status_o", status_o, m_stat);
      check("R3 serr_o", serr_o, rpt_serr_en && (m_stat[2] || m_stat[5]));
      check("R3 perr_o", perr_o, rpt_perr_en && (m_stat[3] || m_stat[4]));
      check("R8/R9 lb_err_o", lb_err_o, e_lb);
      check("R8 rd_data_out", rd_data_out, m_abrd ? {DW{1'b1}} : rd_data_in);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic lb_req(input logic [1:0] k, input logic b, input logic mem);
    lb_req_vld = 1; lb_xfer_kind = k; lb_burst = b; lb_mem_space = mem;
    step();
    lb_req_vld = 0; lb_xfer_kind = 0; lb_burst = 0; lb_mem_space = 0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    csr_wr_en = 1; csr_wdata = 7'h7F;
    step();
    csr_wr_en = 0; csr_wdata = 0;
  endtask

  task automatic pci_cycle(input logic rd, input int dv_at, output int pulses);
    pulses = 0;
    pci_addr_phase = 1; pci_is_read = rd;
    step();
    pci_addr_phase = 0; pci_is_read = 0;
    for (int age = 1; age <= TO + 2; age++) begin
      pci_devsel = (age == dv_at);
      @(negedge clk);
      if (lb_err_o) pulses++;
      step();
    end
    pci_devsel = 0;
    @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", wd);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int p;
    rst_n = 0; det_mask = 0;
    rpt_serr_en = 1; rpt_perr_en = 1; rpt_lb_en = 1; ma_rpt_en = 1;
    lb_req_vld = 0; lb_xfer_kind = 0; lb_burst = 0; lb_mem_space = 0; lb_bus_err_in = 0;
    pci_addr_phase = 0; pci_is_read = 0; pci_devsel = 0;
    pci_tgt_abort = 0; pci_tgt_dperr = 0; pci_mst_dperr = 0; pci_tgt_aperr = 0;
    rd_beat_vld = 0; rd_last = 0; rd_data_in = 32'h0BAD_F00D;
    csr_wr_en = 0; csr_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 status", status_o, 0);
    check("R11 err outs", {serr_o, perr_o, lb_err_o}, 0);
    @(posedge clk); #1 rst_n = 1;

    // unsupported transfer decode
    lb_req(2'd1, 0, 0); check("R4 line4 io", status_o[0], 1);
    clear_all(); @(negedge clk); check("R10 clear", status_o, 0);
    lb_req(2'd2, 0, 1); check("R4 line8 mem", status_o[0], 0);
    lb_req(2'd2, 0, 0); check("R4 line8 io", status_o[0], 1);
    clear_all();
    lb_req(2'd3, 0, 1); check("R5 line16 mem", status_o[0], 1);
    clear_all();
    lb_req(2'd0, 1, 0); check("R6 burst io", status_o[0], 1);
    clear_all();
    lb_req(2'd0, 1, 1); check("R6 burst mem", status_o[0], 0);
    lb_req(2'd0, 0, 0); check("R6 single io", status_o[0], 0);
    det_mask = 7'h01;
    lb_req(2'd3, 0, 0); check("R2 masked unsup", status_o[0], 0);
    det_mask = 0;

    // individual sources and reporting
    pci_tgt_abort = 1; step(); pci_tgt_abort = 0; @(negedge clk);
    check("R1 tgt abort bit", status_o, 7'h04);
    check("R3 serr on", serr_o, 1);
    clear_all();
    pci_tgt_dperr = 1; step(); pci_tgt_dperr = 0; @(negedge clk);
    check("R1 tgt dperr bit", status_o, 7'h08);
    check("R3 perr on", perr_o, 1);
    clear_all();
    pci_mst_dperr = 1; step(); pci_mst_dperr = 0; @(negedge clk);
    check("R1 mst dperr bit", status_o, 7'h10);
    clear_all();
    pci_tgt_aperr = 1; step(); pci_tgt_aperr = 0; @(negedge clk);
    check("R1 aperr bit", status_o, 7'h20);
    clear_all();
    lb_bus_err_in = 1; step(); lb_bus_err_in = 0; @(negedge clk);
    check("R1 lb err bit", status_o, 7'h40);
    clear_all();
    rpt_serr_en = 0;
    pci_tgt_aperr = 1; step(); pci_tgt_aperr = 0; @(negedge clk);
    check("R3 latched while serr masked", status_o[5], 1);
    check("R3 serr masked", serr_o, 0);
    rpt_serr_en = 1; rpt_perr_en = 0;
    pci_mst_dperr = 1; step(); pci_mst_dperr = 0; @(negedge clk);
    check("R3 perr masked", perr_o, 0);
    rpt_perr_en = 1; #1;
    check("R3 perr after enable", perr_o, 1);
    clear_all();

    // master abort timing
    pci_cycle(1, 3, p);  check("R7 devsel early", status_o[1], 0);
    pci_cycle(1, TO, p); check("R7 devsel last cycle", status_o[1], 0);
    pci_cycle(1, 0, p);  check("R7 abort", status_o[1], 1);
    for (int b = 0; b < 4; b++) begin
      rd_beat_vld = 1; rd_last = (b == 3); rd_data_in = 32'h1234_0000 + b;
      @(negedge clk);
      check("R8 forced ones", rd_data_out, 32'hFFFF_FFFF);
      check("R8 beat error", lb_err_o, 1);
      step();
    end
    rd_last = 1; rd_data_in = 32'hA5A5_5A5A;
    @(negedge clk);
    check("R8 after last beat data", rd_data_out, 32'hA5A5_5A5A);
    check("R8 after last beat err", lb_err_o, 0);
    step(); rd_beat_vld = 0; rd_last = 0;
    clear_all();
    pci_cycle(0, 0, p);
    check("R9 write abort pulses", p, 1);
    check("R9 write abort bit", status_o[1], 1);
    clear_all();
    ma_rpt_en = 0;
    pci_cycle(0, 0, p);
    check("R3 ma enable off pulses", p, 0);
    check("R3 ma enable off bit", status_o[1], 1);
    ma_rpt_en = 1;
    clear_all();
    det_mask = 7'h02;
    pci_cycle(1, 0, p);
    check("R2 masked abort bit", status_o[1], 0);
    rd_beat_vld = 1; rd_last = 1; rd_data_in = 32'h0000_C0DE;
    @(negedge clk);
    check("R2 masked abort data", rd_data_out, 32'h0000_C0DE);
    step(); rd_beat_vld = 0; rd_last = 0; det_mask = 0;

    // clear semantics
    pci_tgt_abort = 1; step();
    csr_wr_en = 1; csr_wdata = 7'h04; step();
    pci_tgt_abort = 0; csr_wr_en = 0; csr_wdata = 0; @(negedge clk);
    check("R10 set wins", status_o[2], 1);
    pci_tgt_dperr = 1; step(); pci_tgt_dperr = 0;
    csr_wr_en = 1; csr_wdata = 7'h04; step();
    csr_wr_en = 0; csr_wdata = 0; @(negedge clk);
    check("R10 partial clear", status_o, 7'h08);
    clear_all(); @(negedge clk);
    check("R10 all cleared", status_o, 0);

    repeat (2) step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule